// File: doc/BRIEF.md
# Streaming Instruction Length Decoder

This block accepts a byte stream of variable-length machine code for a 32-bit CISC target and marks where each instruction begins and ends. It takes one byte per cycle and never stalls. For every instruction it sends out a single-cycle record. The record gives the byte offset of the instruction within the stream, its total length, the number of prefix bytes, and the opcode, which is one byte or an escape byte plus a second byte. It also says whether an operand-form byte and a scale/index/base byte were present, and gives the sizes of the displacement and immediate fields.

The decoder works through a fixed, documented subset of opcodes. Any byte outside that subset ends the current instruction with an error record. An instruction that is still incomplete at the maximum length of fifteen bytes also produces an error record, and decoding starts again at the next byte. The block finds instruction boundaries only. It does not execute anything, does not produce text, and does not handle 64-bit extension prefixes or three-byte opcode maps.

Top module: `insnLenDecoder`

## Requirements
- R1: The bytes F0, F2, F3, 26, 2E, 36, 3E, 64, 65, 66 and 67 are prefixes when they appear before the opcode. Any number of them may appear, and each one adds one to the reported prefix count.
- R2: The opcodes 40-5F, 90, C3 and CC need no further bytes. Each one completes its instruction, so the length equals the prefix count plus one.
- R3: The opcodes 00-03, 08-0B, 10-13, 18-1B, 20-23, 28-2B, 30-33, 38-3B, 84-8B and 8D are followed by an operand-form byte with mode in bits 7:6 and r/m in bits 2:0. Under 32-bit addressing the displacement size is set by the mode and r/m fields:
  - mode 11: no displacement.
  - mode 01: 1 byte.
  - mode 10: 4 bytes.
  - mode 00: 4 bytes only when r/m is 101, otherwise none.
- R4: Under 32-bit addressing, r/m 100 with any mode other than 11 adds a scale/index/base byte after the form byte. When that byte's base field (bits 2:0) is 101 and the mode is 00, a 4-byte displacement follows.
- R5: The immediate comes after the displacement. It is 1 byte for:
  - 04, 0C, 14, 1C, 24, 2C, 34, 3C
  - 6A, 70-7F, B0-B7, EB
  - 80, 83, C6 (these also take a form byte)

  It is a full immediate for:
  - 05, 0D, 15, 1D, 25, 2D, 35, 3D
  - 68, B8-BF, E8, E9
  - 69, 81, C7 (these also take a form byte)

  A full immediate is 4 bytes, or 2 bytes when a 66 prefix is present.
- R6: A 67 prefix selects 16-bit addressing. In that mode there is never a scale/index/base byte. The displacement is 2 bytes for mode 10, 2 bytes for mode 00 with r/m 110, 1 byte for mode 01, and none otherwise.
- R7: The byte 0F is an escape. The byte after it selects the operation:
  - 80-8F take a full immediate and no form byte.
  - AF, B6, B7, BE and BF take a form byte.

  The reported opcode is 0F in bits 15:8 and the second byte in bits 7:0. A one-byte opcode is reported with 00 in bits 15:8.
- R8: An opcode byte outside R2, R3, R5 and R7 produces an error record at once, with the length equal to the bytes consumed so far. The next byte begins a new instruction.
- R9: If the fifteenth byte of an instruction does not complete it, an error record with length 15 is produced and the next byte begins a new instruction. An instruction that completes on its fifteenth byte is valid.
- R10: A record is valid for exactly one cycle, the cycle after the clock edge that accepts the instruction's last byte. Its start offset is the number of bytes accepted since reset before the instruction's first byte, so consecutive records are contiguous. The ready output stays high.
- R11: After reset no record is valid, and the first byte accepted has offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A code byte is offered |
| inData | input | 8 | Code byte |
| inReady | output | 1 | Decoder accepts a byte (always high) |
| outValid | output | 1 | Record valid for this cycle |
| outErr | output | 1 | Record ends an unsupported or over-long instruction |
| outStart | output | OffW | Stream offset of the first byte |
| outLen | output | 4 | Total length in bytes |
| outPfxCnt | output | 4 | Number of prefix bytes |
| outOpcode | output | 16 | Opcode; escape byte in bits 15:8 when present |
| outHasForm | output | 1 | Operand-form byte present |
| outHasIndex | output | 1 | Scale/index/base byte present |
| outDispSize | output | 3 | Displacement size in bytes (0, 1, 2, 4) |
| outImmSize | output | 3 | Immediate size in bytes (0, 1, 2, 4) |

## Verification
A wrong parse state moves the boundary of the instruction in which it happens. The record for that instruction then appears a cycle early or late with a length that does not add up from its fields. The start offset of every record after it is shifted too, so a single slip shows in the next record after the error, at most fifteen bytes later. Error handling is checked with resynchronisation runs: when a leftover byte is wrongly consumed, or wrongly not consumed, the instruction that follows decodes with the wrong length.

// File: rtl/insnLenPkg.sv
`timescale 1ns/1ps
package insnLenPkg;
  localparam int MaxLen = 15;
  localparam int LenW = $clog2(MaxLen + 1);

  typedef enum logic [2:0] {S_LEAD, S_ESC2, S_FORM, S_INDEX, S_TAIL} parseState_e;
  typedef enum logic [1:0] {K_BAD, K_PFX, K_ESC, K_OP} opKind_e;
  typedef enum logic [1:0] {I_NONE, I_BYTE, I_FULL} immKind_e;

  typedef struct packed {
    opKind_e  kind;
    logic     needForm;
    immKind_e imm;
  } opInfo_t;

  typedef struct packed {
    logic            take;
    logic            isPrefix;
    logic            setOp16;
    logic            setAddr16;
    logic            loadOp;
    logic            loadOp2;
    logic [2:0]      immSz;
    logic            loadForm;
    logic            indexNext;
    logic            loadIndex;
    logic [2:0]      dispSz;
    logic            loadTail;
    logic [LenW-1:0] tailVal;
    logic            decTail;
    logic            finish;
    logic            bad;
  } ctlStrobe_t;

  function automatic opInfo_t classifyLead(input logic [7:0] b);
    opInfo_t r;
    r = '{kind: K_OP, needForm: 1'b0, imm: I_NONE};
    case (b) inside
      8'hF0, 8'hF2, 8'hF3, 8'h26, 8'h2E, 8'h36, 8'h3E,
      8'h64, 8'h65, 8'h66, 8'h67: r.kind = K_PFX;
      8'h0F: r.kind = K_ESC;
      [8'h40:8'h5F], 8'h90, 8'hC3, 8'hCC: r.imm = I_NONE;
      8'h68, [8'hB8:8'hBF], 8'hE8, 8'hE9: r.imm = I_FULL;
      8'h6A, [8'h70:8'h7F], [8'hB0:8'hB7], 8'hEB: r.imm = I_BYTE;
      8'h80, 8'h83, 8'hC6: begin r.needForm = 1'b1; r.imm = I_BYTE; end
      8'h81, 8'hC7, 8'h69: begin r.needForm = 1'b1; r.imm = I_FULL; end
      [8'h84:8'h8B], 8'h8D: r.needForm = 1'b1;
      default: begin
        if (b < 8'h40 && b[2:0] < 3'd4) r.needForm = 1'b1;
        else if (b < 8'h40 && b[2:0] == 3'd4) r.imm = I_BYTE;
        else if (b < 8'h40 && b[2:0] == 3'd5) r.imm = I_FULL;
        else r.kind = K_BAD;
      end
    endcase
    return r;
  endfunction

  function automatic opInfo_t classifyEsc(input logic [7:0] b);
    opInfo_t r;
    r = '{kind: K_OP, needForm: 1'b0, imm: I_NONE};
    case (b) inside
      [8'h80:8'h8F]: r.imm = I_FULL;
      8'hAF, 8'hB6, 8'hB7, 8'hBE, 8'hBF: r.needForm = 1'b1;
      default: r.kind = K_BAD;
    endcase
    return r;
  endfunction

  function automatic logic [2:0] immBytes(input immKind_e k, input logic op16);
    case (k)
      I_BYTE:  return 3'd1;
      I_FULL:  return op16 ? 3'd2 : 3'd4;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/insnLenCtrl.sv
`timescale 1ns/1ps
module insnLenCtrl
  import insnLenPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [7:0]      inData,
  input  logic [LenW-1:0] curLen,
  input  logic            op16,
  input  logic            addr16,
  input  logic [2:0]      immSz,
  input  logic [2:0]      dispSz,
  input  logic [1:0]      formMode,
  input  logic [LenW-1:0] tailLeft,
  output ctlStrobe_t      ctl
);
  parseState_e state, nextState;
  opInfo_t info;
  logic gotOp, wantTail, useIndex;
  logic [LenW-1:0] tailNeed;
  logic [1:0] mode;
  logic [2:0] rm, dispNew;

  always_comb begin
    ctl = '0;
    nextState = state;
    info = classifyLead(inData);
    gotOp = 1'b0;
    wantTail = 1'b0;
    useIndex = 1'b0;
    tailNeed = '0;
    mode = inData[7:6];
    rm = inData[2:0];
    dispNew = '0;
    if (inValid) begin
      ctl.take = 1'b1;
      unique case (state)
        S_LEAD: begin
          if (info.kind == K_PFX) begin
            ctl.isPrefix = 1'b1;
            ctl.setOp16 = (inData == 8'h66);
            ctl.setAddr16 = (inData == 8'h67);
          end else if (info.kind == K_ESC) begin
            nextState = S_ESC2;
          end else begin
            ctl.loadOp = 1'b1;
            gotOp = 1'b1;
          end
        end
        S_ESC2: begin
          info = classifyEsc(inData);
          ctl.loadOp2 = 1'b1;
          gotOp = 1'b1;
        end
        S_FORM: begin
          if (addr16) begin
            if (mode == 2'b01) dispNew = 3'd1;
            else if (mode == 2'b10) dispNew = 3'd2;
            else if (mode == 2'b00 && rm == 3'b110) dispNew = 3'd2;
          end else begin
            useIndex = (mode != 2'b11) && (rm == 3'b100);
            if (mode == 2'b01) dispNew = 3'd1;
            else if (mode == 2'b10) dispNew = 3'd4;
            else if (mode == 2'b00 && rm == 3'b101) dispNew = 3'd4;
          end
          ctl.loadForm = 1'b1;
          ctl.indexNext = useIndex;
          ctl.dispSz = dispNew;
          if (useIndex) nextState = S_INDEX;
          else begin
            wantTail = 1'b1;
            tailNeed = LenW'(dispNew) + LenW'(immSz);
          end
        end
        S_INDEX: begin
          dispNew = (formMode == 2'b00 && rm == 3'b101) ? 3'd4 : dispSz;
          ctl.loadIndex = 1'b1;
          ctl.dispSz = dispNew;
          wantTail = 1'b1;
          tailNeed = LenW'(dispNew) + LenW'(immSz);
        end
        S_TAIL: begin
          ctl.decTail = 1'b1;
          if (tailLeft == LenW'(1)) ctl.finish = 1'b1;
        end
        default: nextState = S_LEAD;
      endcase
      if (gotOp) begin
        ctl.immSz = immBytes(info.imm, op16);
        if (info.kind != K_OP) begin
          ctl.finish = 1'b1;
          ctl.bad = 1'b1;
        end else if (info.needForm) nextState = S_FORM;
        else begin
          wantTail = 1'b1;
          tailNeed = LenW'(ctl.immSz);
        end
      end
      if (wantTail) begin
        if (tailNeed == '0) ctl.finish = 1'b1;
        else begin
          ctl.loadTail = 1'b1;
          ctl.tailVal = tailNeed;
          nextState = S_TAIL;
        end
      end
      if (!ctl.finish && curLen == LenW'(MaxLen - 1)) begin
        ctl.finish = 1'b1;
        ctl.bad = 1'b1;
      end
      if (ctl.finish) nextState = S_LEAD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_LEAD;
    else state <= nextState;
  end
endmodule

// File: rtl/insnLenData.sv
`timescale 1ns/1ps
module insnLenData
  import insnLenPkg::*;
#(
  parameter int OffW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [7:0]      inData,
  input  ctlStrobe_t      ctl,
  output logic [LenW-1:0] curLen,
  output logic            op16,
  output logic            addr16,
  output logic [2:0]      immSz,
  output logic [2:0]      dispSz,
  output logic [1:0]      formMode,
  output logic [LenW-1:0] tailLeft,
  output logic            outValid,
  output logic            outErr,
  output logic [OffW-1:0] outStart,
  output logic [LenW-1:0] outLen,
  output logic [LenW-1:0] outPfxCnt,
  output logic [15:0]     outOpcode,
  output logic            outHasForm,
  output logic            outHasIndex,
  output logic [2:0]      outDispSize,
  output logic [2:0]      outImmSize
);
  typedef struct packed {
    logic [LenW-1:0] len;
    logic [LenW-1:0] pfxCnt;
    logic            op16;
    logic            addr16;
    logic [15:0]     opcode;
    logic            hasForm;
    logic            hasIndex;
    logic [1:0]      formMode;
    logic [2:0]      dispSz;
    logic [2:0]      immSz;
  } instFields_t;

  instFields_t fld, nxt;
  logic [OffW-1:0] streamOff, startOff;

  assign curLen = fld.len;
  assign op16 = fld.op16;
  assign addr16 = fld.addr16;
  assign immSz = fld.immSz;
  assign dispSz = fld.dispSz;
  assign formMode = fld.formMode;

  always_comb begin
    nxt = fld;
    nxt.len = fld.len + 1'b1;
    if (ctl.isPrefix) begin
      nxt.pfxCnt = fld.pfxCnt + 1'b1;
      nxt.op16 = fld.op16 | ctl.setOp16;
      nxt.addr16 = fld.addr16 | ctl.setAddr16;
    end
    if (ctl.loadOp) begin
      nxt.opcode = {8'h00, inData};
      nxt.immSz = ctl.immSz;
    end
    if (ctl.loadOp2) begin
      nxt.opcode = {8'h0F, inData};
      nxt.immSz = ctl.immSz;
    end
    if (ctl.loadForm) begin
      nxt.hasForm = 1'b1;
      nxt.hasIndex = ctl.indexNext;
      nxt.formMode = inData[7:6];
      nxt.dispSz = ctl.dispSz;
    end
    if (ctl.loadIndex) nxt.dispSz = ctl.dispSz;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fld <= '0;
      tailLeft <= '0;
      streamOff <= '0;
      startOff <= '0;
      outValid <= 1'b0;
      outErr <= 1'b0;
      outStart <= '0;
      outLen <= '0;
      outPfxCnt <= '0;
      outOpcode <= '0;
      outHasForm <= 1'b0;
      outHasIndex <= 1'b0;
      outDispSize <= '0;
      outImmSize <= '0;
    end else begin
      outValid <= ctl.take && ctl.finish;
      if (ctl.take) begin
        streamOff <= streamOff + 1'b1;
        if (fld.len == '0) startOff <= streamOff;
        if (ctl.finish) begin
          fld <= '0;
          tailLeft <= '0;
          outErr <= ctl.bad;
          outStart <= (fld.len == '0) ? streamOff : startOff;
          outLen <= nxt.len;
          outPfxCnt <= nxt.pfxCnt;
          outOpcode <= nxt.opcode;
          outHasForm <= nxt.hasForm;
          outHasIndex <= nxt.hasIndex;
          outDispSize <= nxt.dispSz;
          outImmSize <= nxt.immSz;
        end else begin
          fld <= nxt;
          if (ctl.loadTail) tailLeft <= ctl.tailVal;
          else if (ctl.decTail) tailLeft <= tailLeft - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/insnLenDecoder.sv
`timescale 1ns/1ps
module insnLenDecoder
  import insnLenPkg::*;
#(
  parameter int OffW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [7:0]      inData,
  output logic            inReady,
  output logic            outValid,
  output logic            outErr,
  output logic [OffW-1:0] outStart,
  output logic [3:0]      outLen,
  output logic [3:0]      outPfxCnt,
  output logic [15:0]     outOpcode,
  output logic            outHasForm,
  output logic            outHasIndex,
  output logic [2:0]      outDispSize,
  output logic [2:0]      outImmSize
);
  ctlStrobe_t ctl;
  logic [LenW-1:0] curLen, tailLeft;
  logic op16, addr16;
  logic [2:0] immSz, dispSz;
  logic [1:0] formMode;

  assign inReady = 1'b1;

  insnLenCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .curLen(curLen), .op16(op16), .addr16(addr16), .immSz(immSz),
    .dispSz(dispSz), .formMode(formMode), .tailLeft(tailLeft), .ctl(ctl)
  );

  insnLenData #(.OffW(OffW)) u_data (
    .clk(clk), .rstN(rstN), .inData(inData), .ctl(ctl),
    .curLen(curLen), .op16(op16), .addr16(addr16), .immSz(immSz),
    .dispSz(dispSz), .formMode(formMode), .tailLeft(tailLeft),
    .outValid(outValid), .outErr(outErr), .outStart(outStart),
    .outLen(outLen), .outPfxCnt(outPfxCnt), .outOpcode(outOpcode),
    .outHasForm(outHasForm), .outHasIndex(outHasIndex),
    .outDispSize(outDispSize), .outImmSize(outImmSize)
  );
endmodule

// File: rtl/insnLenDecoderChk.sv
`timescale 1ns/1ps
module insnLenDecoderChk #(
  parameter int OffW = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            outValid,
  input logic            outErr,
  input logic [OffW-1:0] outStart,
  input logic [3:0]      outLen,
  input logic [3:0]      outPfxCnt,
  input logic [15:0]     outOpcode,
  input logic            outHasForm,
  input logic            outHasIndex,
  input logic [2:0]      outDispSize,
  input logic [2:0]      outImmSize
);
  int fieldSum;
  logic haveRec;
  logic [OffW-1:0] expStart;

  always_comb begin
    fieldSum = int'(outPfxCnt) + ((outOpcode[15:8] == 8'h0F) ? 2 : 1)
             + int'(outHasForm) + int'(outHasIndex)
             + int'(outDispSize) + int'(outImmSize);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveRec <= 1'b0;
      expStart <= '0;
    end else if (outValid) begin
      haveRec <= 1'b1;
      expStart <= outStart + OffW'(outLen);
    end
  end

  // R10
  len_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outLen != 4'd0);

  // R3
  field_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outErr) |-> int'(outLen) == fieldSum);

  // R4
  index_needs_form_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outHasIndex) |-> outHasForm);

  // R5
  imm_size_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outErr) |-> (outImmSize inside {3'd0, 3'd1, 3'd2, 3'd4}));

  // R6
  disp_size_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outErr) |-> (outDispSize inside {3'd0, 3'd1, 3'd2, 3'd4}));

  // R10
  contiguous_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && haveRec) |-> outStart == expStart);
endmodule

bind insnLenDecoder insnLenDecoderChk #(.OffW(OffW)) u_chk (
  .clk(clk), .rstN(rstN), .outValid(outValid), .outErr(outErr),
  .outStart(outStart), .outLen(outLen), .outPfxCnt(outPfxCnt),
  .outOpcode(outOpcode), .outHasForm(outHasForm), .outHasIndex(outHasIndex),
  .outDispSize(outDispSize), .outImmSize(outImmSize)
);

// File: tb/test_insnLenDecoder.sv
`timescale 1ns/1ps
module test_insnLenDecoder;
  localparam int OffW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inData = 8'h00;
  logic inReady, outValid, outErr, outHasForm, outHasIndex;
  logic [OffW-1:0] outStart;
  logic [3:0] outLen, outPfxCnt;
  logic [15:0] outOpcode;
  logic [2:0] outDispSize, outImmSize;

  always #2 clk = ~clk;

  insnLenDecoder #(.OffW(OffW)) i_insnLenDecoder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outErr(outErr), .outStart(outStart), .outLen(outLen),
    .outPfxCnt(outPfxCnt), .outOpcode(outOpcode), .outHasForm(outHasForm),
    .outHasIndex(outHasIndex), .outDispSize(outDispSize), .outImmSize(outImmSize)
  );

  int nChecks = 0;
  int nFail = 0;
  int sent = 0;
  int recCount = 0;
  int rStart[64], rLen[64], rPfx[64], rDisp[64], rImm[64];
  logic [15:0] rOp[64];
  logic rForm[64], rIdx[64], rErr[64];
  logic [7:0] seq[$];

  always @(negedge clk) begin
    if (rstN && outValid && recCount < 64) begin
      rStart[recCount] = int'(outStart);
      rLen[recCount] = int'(outLen);
      rPfx[recCount] = int'(outPfxCnt);
      rOp[recCount] = outOpcode;
      rForm[recCount] = outHasForm;
      rIdx[recCount] = outHasIndex;
      rDisp[recCount] = int'(outDispSize);
      rImm[recCount] = int'(outImmSize);
      rErr[recCount] = outErr;
      recCount++;
    end
  end

  task automatic sendSeq();
    for (int i = 0; i < seq.size(); i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inData = seq[i];
    end
    @(negedge clk);
    inValid = 1'b0;
    sent += seq.size();
    seq.delete();
    @(negedge clk);
    #1;
  endtask

  task automatic checkRec(input string req, input int idx, input int st, input int ln,
                          input int pf, input logic [15:0] opc, input logic hf,
                          input logic hi, input int dsp, input int imm, input logic er);
    nChecks++;
    if (idx >= recCount) begin
      nFail++;
      $display("FAIL %s: record %0d missing, actual count=%0d expected >%0d", req, idx, recCount, idx);
    end else if (rStart[idx] != st || rLen[idx] != ln || rPfx[idx] != pf || rOp[idx] != opc ||
                 rForm[idx] != hf || rIdx[idx] != hi || rDisp[idx] != dsp || rImm[idx] != imm ||
                 rErr[idx] != er) begin
      nFail++;
      $display("FAIL %s: actual start=%0d len=%0d pfx=%0d op=%h form=%b idx=%b disp=%0d imm=%0d err=%b expected start=%0d len=%0d pfx=%0d op=%h form=%b idx=%b disp=%0d imm=%0d err=%b",
               req, rStart[idx], rLen[idx], rPfx[idx], rOp[idx], rForm[idx], rIdx[idx],
               rDisp[idx], rImm[idx], rErr[idx], st, ln, pf, opc, hf, hi, dsp, imm, er);
    end
  endtask

  task automatic checkCount(input string req, input int expCount);
    nChecks++;
    if (recCount != expCount) begin
      nFail++;
      $display("FAIL %s: record count actual=%0d expected=%0d", req, recCount, expCount);
    end
  endtask

  task automatic runOne(input string req, input int ln, input int pf, input logic [15:0] opc,
                        input logic hf, input logic hi, input int dsp, input int imm,
                        input logic er);
    int base, st;
    base = recCount;
    st = sent;
    sendSeq();
    checkCount(req, base + 1);
    checkRec(req, base, st, ln, pf, opc, hf, hi, dsp, imm, er);
  endtask

  task automatic tReset();
    nChecks++;
    if (outValid !== 1'b0) begin
      nFail++;
      $display("FAIL R11: outValid during reset actual=%b expected=0", outValid);
    end
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    nChecks++;
    if (outValid !== 1'b0 || inReady !== 1'b1) begin
      nFail++;
      $display("FAIL R11: after reset outValid=%b inReady=%b expected 0/1", outValid, inReady);
    end
  endtask

  task automatic tSingleByte();
    seq = '{8'h90}; runOne("R11 first offset, R2 nop", 1, 0, 16'h0090, 0, 0, 0, 0, 0);
    seq = '{8'h50}; runOne("R2 push", 1, 0, 16'h0050, 0, 0, 0, 0, 0);
    seq = '{8'hF3, 8'hC3}; runOne("R2 R1 prefixed return", 2, 1, 16'h00C3, 0, 0, 0, 0, 0);
  endtask

  task automatic tForm();
    seq = '{8'h89, 8'hD8}; runOne("R3 register form", 2, 0, 16'h0089, 1, 0, 0, 0, 0);
    seq = '{8'h8B, 8'h45, 8'h08}; runOne("R3 mode01", 3, 0, 16'h008B, 1, 0, 1, 0, 0);
    seq = '{8'h8B, 8'h05, 8'h11, 8'h22, 8'h33, 8'h44}; runOne("R3 mode00 rm101", 6, 0, 16'h008B, 1, 0, 4, 0, 0);
    seq = '{8'h8B, 8'h85, 8'h11, 8'h22, 8'h33, 8'h44}; runOne("R3 mode10", 6, 0, 16'h008B, 1, 0, 4, 0, 0);
  endtask

  task automatic tIndex();
    seq = '{8'hF3, 8'h36, 8'hC7, 8'h84, 8'hD8, 8'h44, 8'h33, 8'h22, 8'h11, 8'h88, 8'h77, 8'h66, 8'h55};
    runOne("R4 R1 13-byte store", 13, 2, 16'h00C7, 1, 1, 4, 4, 0);
    seq = '{8'h8B, 8'h44, 8'h24, 8'h08}; runOne("R4 index mode01", 4, 0, 16'h008B, 1, 1, 1, 0, 0);
    seq = '{8'h8B, 8'h04, 8'h25, 8'h01, 8'h02, 8'h03, 8'h04}; runOne("R4 base101 mode00", 7, 0, 16'h008B, 1, 1, 4, 0, 0);
  endtask

  task automatic tImm();
    seq = '{8'h80, 8'hC1, 8'h11}; runOne("R5 form plus imm8", 3, 0, 16'h0080, 1, 0, 0, 1, 0);
    seq = '{8'h66, 8'hC7, 8'hC0, 8'h34, 8'h12}; runOne("R5 operand-size shrink", 5, 1, 16'h00C7, 1, 0, 0, 2, 0);
    seq = '{8'h66, 8'hB8, 8'h34, 8'h12}; runOne("R5 short full imm", 4, 1, 16'h00B8, 0, 0, 0, 2, 0);
    seq = '{8'hE8, 8'h01, 8'h02, 8'h03, 8'h04}; runOne("R5 call imm32", 5, 0, 16'h00E8, 0, 0, 0, 4, 0);
  endtask

  task automatic tAddr16();
    seq = '{8'h67, 8'h8B, 8'h06, 8'h34, 8'h12}; runOne("R6 mode00 rm110", 5, 1, 16'h008B, 1, 0, 2, 0, 0);
    seq = '{8'h67, 8'h8B, 8'h84, 8'h34, 8'h12}; runOne("R6 no index byte", 5, 1, 16'h008B, 1, 0, 2, 0, 0);
  endtask

  task automatic tEscape();
    seq = '{8'h0F, 8'h84, 8'h01, 8'h02, 8'h03, 8'h04}; runOne("R7 escaped branch", 6, 0, 16'h0F84, 0, 0, 0, 4, 0);
    seq = '{8'h0F, 8'hB6, 8'hC1}; runOne("R7 escaped with form", 3, 0, 16'h0FB6, 1, 0, 0, 0, 0);
  endtask

  task automatic tBadOp();
    seq = '{8'hF4}; runOne("R8 unsupported lead", 1, 0, 16'h00F4, 0, 0, 0, 0, 1);
    seq = '{8'h90}; runOne("R8 resync after error", 1, 0, 16'h0090, 0, 0, 0, 0, 0);
    seq = '{8'h66, 8'hF4}; runOne("R8 unsupported after prefix", 2, 1, 16'h00F4, 0, 0, 0, 0, 1);
    seq = '{8'h0F, 8'h05}; runOne("R8 unsupported escaped", 2, 0, 16'h0F05, 0, 0, 0, 0, 1);
  endtask

  task automatic tTooLong();
    int base, st;
    for (int i = 0; i < 15; i++) seq.push_back(8'h66);
    runOne("R9 fifteen prefixes", 15, 15, 16'h0000, 0, 0, 0, 0, 1);
    for (int i = 0; i < 14; i++) seq.push_back(8'h66);
    seq.push_back(8'h90);
    runOne("R9 exactly fifteen", 15, 14, 16'h0090, 0, 0, 0, 0, 0);
    base = recCount;
    st = sent;
    for (int i = 0; i < 14; i++) seq.push_back(8'h66);
    seq.push_back(8'hB8);
    seq.push_back(8'h34);
    seq.push_back(8'h12);
    sendSeq();
    checkCount("R9 overflow resync count", base + 2);
    checkRec("R9 overflow in tail", base, st, 15, 14, 16'h00B8, 0, 0, 0, 2, 1);
    checkRec("R9 leftover bytes decode", base + 1, st + 15, 2, 0, 16'h0034, 0, 0, 0, 1, 0);
  endtask

  task automatic tStream();
    int base, st;
    base = recCount;
    st = sent;
    seq = '{8'h90, 8'h89, 8'hD8, 8'hCC};
    sendSeq();
    checkCount("R10 back-to-back count", base + 3);
    checkRec("R10 stream first", base, st, 1, 0, 16'h0090, 0, 0, 0, 0, 0);
    checkRec("R10 stream second", base + 1, st + 1, 2, 0, 16'h0089, 1, 0, 0, 0, 0);
    checkRec("R10 stream third", base + 2, st + 3, 1, 0, 16'h00CC, 0, 0, 0, 0, 0);
  endtask

  task automatic tPulse();
    seq = '{8'h90};
    for (int i = 0; i < seq.size(); i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inData = seq[i];
    end
    @(negedge clk);
    inValid = 1'b0;
    nChecks++;
    if (outValid !== 1'b1) begin
      nFail++;
      $display("FAIL R10: outValid after last byte actual=%b expected=1", outValid);
    end
    @(negedge clk);
    nChecks++;
    if (outValid !== 1'b0) begin
      nFail++;
      $display("FAIL R10: outValid second cycle actual=%b expected=0", outValid);
    end
    sent += 1;
    seq.delete();
  endtask

  initial begin
    #(4 * 100000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    tSingleByte();
    tForm();
    tIndex();
    tImm();
    tAddr16();
    tEscape();
    tBadOp();
    tTooLong();
    tStream();
    tPulse();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule